// File: doc/BRIEF.md
# Framed Serial PCM Transmit Port

This block sends one 8-bit companded codeword per frame on a single serial data line. It runs in a fast master-clock domain. The frame-sync input and the bit-clock input are both asynchronous to that domain, so each passes through a flop synchronizer before its edges are detected. A synchronized rise of frame sync does four things at once. It turns on the line driver enable. It latches the codeword offered on the parallel input, or a fixed idle code when no word is ready. It puts the first bit on the line. It issues a one-cycle conversion-start pulse so that the next sample can be prepared.

While sync stays high, each synchronized rising bit-clock edge moves the line to the next bit. Bits go out sign first, then the three segment bits, then the four step bits, most significant first. After the last bit the line holds its value until sync falls. When sync falls, the enable is withdrawn and the line is parked low. The driver enable follows the sync level directly; no bit counter controls it. A new frame that begins after too short a low gap on sync raises an error pulse.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, sdo_oe, sdo_out, conv_start and frame_err are all 0.
- R2: sdo_oe equals the level that sync_in had SYNC_STAGES+1 master clocks earlier (3 clocks by default). Whenever sdo_oe is 0, sdo_out is 0.
- R3: In the cycle that sdo_oe rises, sdo_out already carries bit 7 (the sign bit) of the latched word.
- R4: Each rising bit-clock edge seen while sync is high advances sdo_out by one bit, in the order bit 7 down to bit 0 (sign, then segment bits 6..4, then step bits 3..0). sdo_out is unchanged in any cycle that does not follow a detected bit-clock rise.
- R5: After seven advances, further bit-clock rises within the same frame leave sdo_out at bit 0.
- R6: Bit-clock rises while sync is low have no effect. A bit-clock rise detected in the same master cycle as the sync rise is not counted, so the sync edge alone defines the first bit.
- R7: If word_rdy is 0 at the sync rise, the frame sends IDLE_WORD (default 8'hD5) instead of word_in.
- R8: conv_start is a single-cycle pulse. Exactly one occurs per frame, in the cycle in which sdo_oe rises.
- R9: frame_err pulses together with conv_start when synchronized sync was low for fewer than MIN_GAP master cycles (default 2) before the rise. A gap of MIN_GAP cycles or more gives no error. The frame is sent normally in either case.
- R10: Changes on word_in or word_rdy after the sync rise do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Frame sync, asynchronous to clk |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| word_in | input | WORD_W | Codeword to send in the next frame |
| word_rdy | input | 1 | word_in holds a fresh codeword |
| sdo_out | output | 1 | Serial data |
| sdo_oe | output | 1 | Line driver enable (tri-state control) |
| conv_start | output | 1 | One-cycle pulse requesting the next conversion |
| frame_err | output | 1 | Pulse: sync low gap before this frame was too short |

## Verification
All 256 codewords are each sent in a full frame. Each frame is clocked past eight bits, which separates bit order and hold-at-last-bit faults from load faults. Other frames check specific timing cases: a frame with the ready flag low, a frame whose word input changes mid-frame, bit-clock pulses during the sync-low gap, and a bit-clock edge that arrives together with the sync edge. These show whether stray edges advance the bit pointer. Sync-low gaps of exactly one and exactly two master cycles bracket the error threshold. A running count of conversion pulses shows whether each frame issued exactly one.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int unsigned DEF_WORD_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_MIN_GAP     = 2;

    // Which source feeds the shift register at a frame start
    typedef enum logic [0:0] {
        SRC_IDLE = 1'b0,
        SRC_WORD = 1'b1
    } load_src_e;

endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level_out,
    output logic [W-1:0] rise_out
);

    localparam int unsigned DEPTH = STAGES + 1;

    // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_edge
            assign level_out[g] = pipe_q[STAGES-1][g];
            assign rise_out[g]  = pipe_q[STAGES-1][g] & ~pipe_q[STAGES][g];
        end
    endgenerate

endmodule

// File: rtl/pcm_tx_gap.sv
module pcm_tx_gap #(
    parameter int unsigned MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl,
    input  logic sync_rise,
    output logic gap_err
);

    localparam int unsigned CNT_W = $clog2(MIN_GAP + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_GAP);

    typedef struct packed {
        logic [CNT_W-1:0] low_cnt;
        logic             err;
    } gap_state_t;

    gap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (sync_rise) begin
            st_d.err     = (st_q.low_cnt < CNT_SAT);
            st_d.low_cnt = '0;
        end else if (!sync_lvl) begin
            if (st_q.low_cnt != CNT_SAT) st_d.low_cnt = st_q.low_cnt + 1'b1;
        end else begin
            st_d.low_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.low_cnt <= CNT_SAT;   // the first frame after reset is never short
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gap_err = st_q.err;

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_tx_pkg::*;
#(
    parameter int unsigned       WORD_W    = DEF_WORD_W,
    parameter logic [WORD_W-1:0] IDLE_WORD = WORD_W'(8'hD5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_lvl,
    input  logic              sync_rise,
    input  logic              bclk_rise,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_rdy,
    output logic              sdo,
    output logic              oe,
    output logic              conv
);

    localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  bit_cnt;
        logic              oe;
        logic              conv;
    } sh_state_t;

    sh_state_t st_d, st_q;
    load_src_e src;

    always_comb begin
        src = word_rdy ? SRC_WORD : SRC_IDLE;
    end

    always_comb begin
        st_d      = st_q;
        st_d.conv = 1'b0;
        if (sync_rise) begin
            // the sync edge is the first shift edge; a coincident bit-clock rise is dropped
            st_d.shreg   = (src == SRC_WORD) ? word_in : IDLE_WORD;
            st_d.bit_cnt = '0;
            st_d.oe      = 1'b1;
            st_d.conv    = 1'b1;
        end else if (!sync_lvl) begin
            st_d.oe      = 1'b0;
            st_d.bit_cnt = '0;
        end else if (bclk_rise && (st_q.bit_cnt != LAST_BIT)) begin
            st_d.shreg   = {st_q.shreg[WORD_W-2:0], 1'b0};
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo  = st_q.oe & st_q.shreg[WORD_W-1];
    assign oe   = st_q.oe;
    assign conv = st_q.conv;

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
    import pcm_tx_pkg::*;
#(
    parameter int unsigned       WORD_W      = DEF_WORD_W,
    parameter int unsigned       SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned       MIN_GAP     = DEF_MIN_GAP,
    parameter logic [WORD_W-1:0] IDLE_WORD   = WORD_W'(8'hD5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              bclk_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_rdy,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              conv_start,
    output logic              frame_err
);

    localparam int unsigned IDX_SYNC = 0;
    localparam int unsigned IDX_BCLK = 1;

    logic [1:0] lvl, rise;
    logic       sync_lvl, sync_rise, bclk_rise;

    pcm_tx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bclk_in, sync_in}),
        .level_out(lvl),
        .rise_out (rise)
    );

    assign sync_lvl  = lvl[IDX_SYNC];
    assign sync_rise = rise[IDX_SYNC];
    assign bclk_rise = rise[IDX_BCLK] & lvl[IDX_SYNC];

    pcm_tx_shifter #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .sync_rise(sync_rise),
        .bclk_rise(bclk_rise),
        .word_in  (word_in),
        .word_rdy (word_rdy),
        .sdo      (sdo_out),
        .oe       (sdo_oe),
        .conv     (conv_start)
    );

    pcm_tx_gap #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .sync_rise(sync_rise),
        .gap_err  (frame_err)
    );

endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sdo_out,
    input logic sdo_oe,
    input logic conv_start,
    input logic frame_err,
    input logic bclk_rise
);

    assert_line_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo_out);

    assert_conv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_conv_at_oe_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (sdo_oe && !$past(sdo_oe)));

    assert_oe_rise_has_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !$past(sdo_oe)) |-> conv_start);

    assert_err_with_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> conv_start);

    assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(bclk_rise)) |-> $stable(sdo_out));

endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo_out   (sdo_out),
    .sdo_oe    (sdo_oe),
    .conv_start(conv_start),
    .frame_err (frame_err),
    .bclk_rise (bclk_rise)
);

// File: tb/pcm_tx_port_test.sv
module pcm_tx_port_test;

    localparam int unsigned W    = 8;
    localparam logic [7:0]  IDLE = 8'hD5;
    localparam int unsigned LAT  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_in = 1'b0;
    logic         bclk_in = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         word_rdy = 1'b0;
    logic         sdo_out, sdo_oe, conv_start, frame_err;

    int checks = 0;
    int errors = 0;
    int conv_seen = 0;
    int frames = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcm_tx_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .bclk_in   (bclk_in),
        .word_in   (word_in),
        .word_rdy  (word_rdy),
        .sdo_out   (sdo_out),
        .sdo_oe    (sdo_oe),
        .conv_start(conv_start),
        .frame_err (frame_err)
    );

    always @(negedge clk) if (rst_n && conv_start) conv_seen++;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit-clock pulse followed by the expected line value
    task automatic bclk_pulse(input string req, input logic exp_bit);
        bclk_in = 1'b1;
        tick(LAT);
        check(req, sdo_out, exp_bit);
        bclk_in = 1'b0;
        tick(2);
    endtask

    task automatic start_frame(input logic [W-1:0] w, input logic rdy, input logic exp_err);
        logic [W-1:0] sent;
        sent = rdy ? w : IDLE;
        word_in  = w;
        word_rdy = rdy;
        sync_in  = 1'b1;
        frames++;
        tick(LAT - 1);
        check("R2 oe still low before latency", sdo_oe, 0);
        tick(1);
        check("R2 oe on", sdo_oe, 1);
        check("R8 conv pulse", conv_start, 1);
        check("R9 frame_err", frame_err, exp_err);
        check("R3 first bit", sdo_out, sent[W-1]);
        tick(1);
        check("R8 conv single", conv_start, 0);
    endtask

    task automatic end_frame(input int gap);
        sync_in = 1'b0;
        tick(LAT);
        check("R2 oe off", sdo_oe, 0);
        check("R2 line parked", sdo_out, 0);
        if (gap > 0) tick(gap);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R1 oe", sdo_oe, 0);
        check("R1 sdo", sdo_out, 0);
        check("R1 conv", conv_start, 0);
        check("R1 err", frame_err, 0);
        rst_n = 1'b1;
        tick(2);

        // R4 R5: every codeword, eight bits then two extra edges
        for (int w = 0; w < 256; w++) begin
            logic [W-1:0] cw;
            cw = W'(w);
            start_frame(cw, 1'b1, 1'b0);
            for (int b = 1; b < W + 2; b++) begin
                int idx;
                idx = (b < W) ? (W - 1 - b) : 0;
                bclk_pulse((b < W) ? "R4 bit order" : "R5 hold last", cw[idx]);
            end
            end_frame(2);
        end

        // R7: ready low sends the idle code
        start_frame(8'h3C, 1'b0, 1'b0);
        for (int b = 1; b < W; b++) bclk_pulse("R7 idle word", IDLE[W-1-b]);
        end_frame(2);

        // R10: word_in and ready change mid-frame
        start_frame(8'hA6, 1'b1, 1'b0);
        word_in  = 8'h59;
        word_rdy = 1'b0;
        for (int b = 1; b < W; b++) begin
            logic [7:0] ref_w;
            ref_w = 8'hA6;
            bclk_pulse("R10 word held", ref_w[W-1-b]);
        end
        end_frame(0);

        // R6: bit clocks during the sync-low gap do nothing
        for (int k = 0; k < 4; k++) begin
            bclk_in = 1'b1; tick(3);
            check("R6 idle line", sdo_out, 0);
            bclk_in = 1'b0; tick(2);
        end
        start_frame(8'h81, 1'b1, 1'b0);
        bclk_pulse("R6 second bit after gap clocks", 1'b0);
        end_frame(2);

        // R6: bit clock rising together with sync is not counted
        word_in  = 8'hC3;
        word_rdy = 1'b1;
        sync_in  = 1'b1;
        bclk_in  = 1'b1;
        frames++;
        tick(LAT);
        check("R6 coincident edge keeps sign bit", sdo_out, 1);
        check("R8 conv on coincident", conv_start, 1);
        bclk_in = 1'b0; tick(2);
        bclk_pulse("R6 next bit is bit6", 1'b1);
        bclk_pulse("R6 then bit5", 1'b0);
        end_frame(2);

        // R9: gap of one cycle flags, gap of MIN_GAP does not
        start_frame(8'h10, 1'b1, 1'b0);
        sync_in = 1'b0;
        tick(1);
        start_frame(8'hF0, 1'b1, 1'b1);
        bclk_pulse("R9 short-gap frame still sent", 1'b1);
        sync_in = 1'b0;
        tick(2);
        start_frame(8'h0F, 1'b1, 1'b0);
        bclk_pulse("R9 boundary frame", 1'b0);
        end_frame(2);

        check("R8 one conv per frame", conv_seen, frames);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule